// File: doc/BRIEF.md
# Crash log capture control unit

This block is the register-side controller for a single crash-log record. Software reaches it through a plain 32-bit register bus with a write strobe and an address-decoded, combinational read port. The first four words form a discovery header. It gives the access mode, record type and layout version, an identifier, a base offset and the log length in 32-bit words. A control window follows at a parameterised base address. This window carries the status and the control of the capture lifecycle.

A capture starts either from a software execute request or from the external crash event input. The memory that stores the log and the agent that writes it are not part of the block. A down-counting fill timer models them with a fixed latency. While the timer runs, the record is in progress. When it expires, the record is complete. Software can then consume it, clear it so that a new capture is possible, rearm it, or disable the unit. A request that is not accepted leaves an error mark.

Two register layouts are selected at elaboration by `LAYOUT_VER`. Layout 0 folds status and control into one word at the window base. Layout 2 keeps a status word at the window base and a control word 0x14 above it. Both layouts drive the same lifecycle logic.

Top module: `crashrec_ctrl`

## Requirements
- R1: The header word at address 0x00 reads access kind in bits 3:0, value 1 in bits 7:4 and `LAYOUT_VER` in bits 19:16, with all other bits 0. Address 0x04 reads the identifier, 0x08 the base offset and 0x0C the log length in 32-bit words.
- R2: After a synchronous active-low reset the unit is enabled and every lifecycle flag is 0. The only exception is layout 2: its status word has bit 20 (clear supported) tied to 1, so it reads 0x0010_0000.
- R3: A capture can be started by an execute request or by a one-cycle `crash_evt` pulse. Once accepted, in-progress (layout 2 status bit 30) is 1 for exactly `FILL_CYCLES` cycles. In the following cycle in-progress is 0 and complete (status bit 31 in both layouts) is 1.
- R4: An execute request or a crash event has no effect while the unit is disabled, while complete is 1, or while a capture is already in progress. A repeated request does not restart the fill timer.
- R5: In layout 2, consume (control bit 25) sets consumed (status bit 27) only when complete is 1 and the unit is enabled. Any other consume sets error (status bit 26). Error stays 1 until a clear.
- R6: A clear resets complete, consumed, in-progress and error, and sets cleared (layout 2 status bit 29). Clear is bit 30 of the control word in layout 2 and bit 29 of the combined word in layout 0.
- R7: In layout 2, rearm (control bit 28) sets rearmed (status bit 25). An accepted capture resets both cleared and rearmed.
- R8: Disable is a level that keeps its written value: bit 31 of the layout 2 control word and bit 28 of the layout 0 word. It reads back at that position, and layout 2 status bit 28 mirrors it. All other control bits are one-shot and read back as 0. Writes to the layout 2 status word change nothing.
- R9: In layout 0 the word at the window base reads complete in bit 31 and disable in bit 28, and executes on bit 30. Writing back a value just read fires no action. Address base+0x14 is not decoded and reads 0.
- R10: When clear arrives in the same write as execute or consume, clear takes effect. The same-write execute or consume is dropped, and no capture starts and no error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the word being read or written |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| crash_evt | input | 1 | Hardware crash event, one pulse per request |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The assertions assume a few things about the inputs. Writes and crash events are synchronous to `clk` and are sampled at the edge where they are high. Every write lands on a word-aligned address, and each write is a complete word, so no byte-lane merging takes place. The bench keeps inside these limits. It changes inputs just after a rising edge, holds each write strobe or event for exactly one cycle, and uses only the decoded word addresses plus one undecoded one. Read data is sampled on the falling edge, after the state from the preceding rising edge has settled.

// File: rtl/crashrec_pkg.sv
package crashrec_pkg;

  localparam int REC_TYPE = 1;

  // layout 2 status bit positions
  localparam int S2_CLRSUP   = 20;
  localparam int S2_REARMED  = 25;
  localparam int S2_ERROR    = 26;
  localparam int S2_CONSUMED = 27;
  localparam int S2_DISABLED = 28;
  localparam int S2_CLEARED  = 29;
  localparam int S2_BUSY     = 30;
  localparam int S2_COMPLETE = 31;

  typedef struct packed {
    logic complete;
    logic busy;
    logic cleared;
    logic consumed;
    logic error;
    logic rearmed;
    logic disabled;
  } crash_flags_t;

  function automatic logic [31:0] hdr_word(input logic [3:0] acc, input logic [3:0] ver);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = acc;
    w[7:4]   = 4'(REC_TYPE);
    w[19:16] = ver;
    return w;
  endfunction

  function automatic logic [31:0] v2_status(input crash_flags_t f);
    logic [31:0] w;
    w              = '0;
    w[S2_CLRSUP]   = 1'b1;
    w[S2_REARMED]  = f.rearmed;
    w[S2_ERROR]    = f.error;
    w[S2_CONSUMED] = f.consumed;
    w[S2_DISABLED] = f.disabled;
    w[S2_CLEARED]  = f.cleared;
    w[S2_BUSY]     = f.busy;
    w[S2_COMPLETE] = f.complete;
    return w;
  endfunction

  function automatic logic [31:0] v0_word(input crash_flags_t f);
    logic [31:0] w;
    w     = '0;
    w[31] = f.complete;
    w[28] = f.disabled;
    return w;
  endfunction

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/crashrec_fill_timer.sv
module crashrec_fill_timer import crashrec_pkg::*; #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = cnt_bits(CYCLES);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES);
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  // R3: a running capture always has cycles left to count
  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));

  // R3: a start that is not aborted enters the busy phase
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> busy);

endmodule

// File: rtl/crashrec_lifecycle.sv
module crashrec_lifecycle import crashrec_pkg::*; (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_req,
  input  logic         cons_req,
  input  logic         clr_req,
  input  logic         rearm_req,
  input  logic         dis_lvl,
  input  logic         fill_busy,
  input  logic         fill_done,
  output logic         start_ok,
  output crash_flags_t flags
);
  logic complete_q, cleared_q, consumed_q, error_q, rearmed_q;
  logic cons_ok, cons_bad;

  assign start_ok = exec_req && !dis_lvl && !complete_q && !fill_busy && !clr_req;
  assign cons_ok  = cons_req && !clr_req && complete_q && !dis_lvl;
  assign cons_bad = cons_req && !clr_req && !cons_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      complete_q <= 1'b0;
      cleared_q  <= 1'b0;
      consumed_q <= 1'b0;
      error_q    <= 1'b0;
    end else if (clr_req) begin
      complete_q <= 1'b0;
      consumed_q <= 1'b0;
      error_q    <= 1'b0;
      cleared_q  <= 1'b1;
    end else begin
      if (fill_done) complete_q <= 1'b1;
      if (cons_ok)   consumed_q <= 1'b1;
      if (cons_bad)  error_q    <= 1'b1;
      if (start_ok)  cleared_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rearmed_q <= 1'b0;
    else if (start_ok)  rearmed_q <= 1'b0;
    else if (rearm_req) rearmed_q <= 1'b1;
  end

  always_comb begin
    flags          = '0;
    flags.complete = complete_q;
    flags.busy     = fill_busy;
    flags.cleared  = cleared_q;
    flags.consumed = consumed_q;
    flags.error    = error_q;
    flags.rearmed  = rearmed_q;
    flags.disabled = dis_lvl;
  end

  // R3: timer expiry moves the record to complete
  a_r3_done_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && !clr_req) |=> (complete_q && !fill_busy));

  // R3: in progress and complete never coexist
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(complete_q && fill_busy));

  // R4: a request while disabled and idle leaves the timer idle
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && dis_lvl && !fill_busy) |=> !fill_busy);

  // R5: consume without a complete record raises error
  a_r5_reject_error: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_req && !clr_req && !complete_q) |=> error_q);

  // R5: accepted consume marks the record consumed
  a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_req && !clr_req && complete_q && !dis_lvl) |=> consumed_q);

  // R6: clear effect on the flags and the timer
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (cleared_q && !complete_q && !consumed_q && !error_q && !fill_busy));

  // R7: an accepted capture drops cleared and rearmed
  a_r7_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && !dis_lvl && !complete_q && !fill_busy && !clr_req)
      |=> (fill_busy && !cleared_q && !rearmed_q));

endmodule

// File: rtl/crashrec_regfile.sv
module crashrec_regfile import crashrec_pkg::*; #(
  parameter int          LAYOUT_VER  = 2,
  parameter int          ADDR_W      = 8,
  parameter int unsigned CTRL_BASE   = 32,
  parameter logic [3:0]  ACCESS_KIND = 4'd0,
  parameter logic [31:0] RECORD_ID   = 32'h0,
  parameter logic [31:0] BASE_OFS    = 32'h0,
  parameter logic [31:0] LOG_WORDS   = 32'd256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  crash_flags_t      flags,
  output logic [31:0]       bus_rdata,
  output logic              dis_lvl,
  output logic              exec_wr,
  output logic              cons_wr,
  output logic              clr_wr,
  output logic              rearm_wr
);
  localparam logic [ADDR_W-1:0] A_HDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + 32'h14);

  logic        dis_wr, dis_val;
  logic [31:0] stat_rd, ctl_rd;

  generate
    if (LAYOUT_VER == 0) begin : g_combined
      logic sel;
      logic unused_wbits;
      assign sel          = bus_wr && (bus_addr == A_STAT);
      assign exec_wr      = sel && bus_wdata[30];
      assign clr_wr       = sel && bus_wdata[29];
      assign cons_wr      = 1'b0;
      assign rearm_wr     = 1'b0;
      assign dis_wr       = sel;
      assign dis_val      = bus_wdata[28];
      assign stat_rd      = v0_word(flags);
      assign ctl_rd       = '0;
      assign unused_wbits = ^{bus_wdata[31], bus_wdata[27:0]};
    end else begin : g_split
      logic sel;
      logic unused_wbits;
      assign sel          = bus_wr && (bus_addr == A_CTRL);
      assign cons_wr      = sel && bus_wdata[25];
      assign rearm_wr     = sel && bus_wdata[28];
      assign exec_wr      = sel && bus_wdata[29];
      assign clr_wr       = sel && bus_wdata[30];
      assign dis_wr       = sel;
      assign dis_val      = bus_wdata[31];
      assign stat_rd      = v2_status(flags);
      assign ctl_rd       = {dis_lvl, 31'b0};
      assign unused_wbits = ^{bus_wdata[27:26], bus_wdata[24:0]};

      // R8: only the disable level is visible in the control word
      a_r8_ctrl_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[30:0] == 31'b0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      dis_lvl <= 1'b0;
    else if (dis_wr) dis_lvl <= dis_val;
  end

  always_comb begin
    case (bus_addr)
      A_HDR:   bus_rdata = hdr_word(ACCESS_KIND, 4'(LAYOUT_VER));
      A_ID:    bus_rdata = RECORD_ID;
      A_BASE:  bus_rdata = BASE_OFS;
      A_SIZE:  bus_rdata = LOG_WORDS;
      A_STAT:  bus_rdata = stat_rd;
      A_CTRL:  bus_rdata = ctl_rd;
      default: bus_rdata = '0;
    endcase
  end

  // R8: disable level moves only on a write to the decoded word
  a_r8_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(dis_lvl));

endmodule

// File: rtl/crashrec_ctrl.sv
module crashrec_ctrl import crashrec_pkg::*; #(
  parameter int          LAYOUT_VER  = 2,
  parameter int          ADDR_W      = 8,
  parameter int unsigned CTRL_BASE   = 32,
  parameter int          FILL_CYCLES = 16,
  parameter logic [3:0]  ACCESS_KIND = 4'd0,
  parameter logic [31:0] RECORD_ID   = 32'h0,
  parameter logic [31:0] BASE_OFS    = 32'h0,
  parameter logic [31:0] LOG_WORDS   = 32'd256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              crash_evt,
  output logic [31:0]       bus_rdata
);
  crash_flags_t flags;
  logic dis_lvl, exec_wr, cons_wr, clr_wr, rearm_wr;
  logic exec_req, start_ok, fill_busy, fill_done;

  assign exec_req = exec_wr || crash_evt;

  crashrec_regfile #(
    .LAYOUT_VER (LAYOUT_VER),
    .ADDR_W     (ADDR_W),
    .CTRL_BASE  (CTRL_BASE),
    .ACCESS_KIND(ACCESS_KIND),
    .RECORD_ID  (RECORD_ID),
    .BASE_OFS   (BASE_OFS),
    .LOG_WORDS  (LOG_WORDS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .flags    (flags),
    .bus_rdata(bus_rdata),
    .dis_lvl  (dis_lvl),
    .exec_wr  (exec_wr),
    .cons_wr  (cons_wr),
    .clr_wr   (clr_wr),
    .rearm_wr (rearm_wr)
  );

  crashrec_lifecycle u_life (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_req (exec_req),
    .cons_req (cons_wr),
    .clr_req  (clr_wr),
    .rearm_req(rearm_wr),
    .dis_lvl  (dis_lvl),
    .fill_busy(fill_busy),
    .fill_done(fill_done),
    .start_ok (start_ok),
    .flags    (flags)
  );

  crashrec_fill_timer #(.CYCLES(FILL_CYCLES)) u_fill (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start_ok),
    .abort(clr_wr),
    .busy (fill_busy),
    .done (fill_done)
  );

  // R4: a running capture is never restarted by a new request
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && exec_req) |-> !start_ok);

  // R10: clear in the same cycle suppresses any start
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && exec_req) |=> !fill_busy);

endmodule

// File: tb/crashrec_ctrl_bench.sv
module crashrec_ctrl_bench;
  localparam int FILL = 5;
  localparam logic [7:0] S = 8'h20;
  localparam logic [7:0] C = 8'h34;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr2 = 1'b0, wr0 = 1'b0, evt2 = 1'b0, evt0 = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd2, rd0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  typedef struct { logic sel0; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  crashrec_ctrl #(.LAYOUT_VER(2), .FILL_CYCLES(FILL), .ACCESS_KIND(4'd2),
    .RECORD_ID(32'hC0DE_5A17), .BASE_OFS(32'h0000_0100), .LOG_WORDS(32'd64)) u_crashrec_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr2), .bus_wdata(wdata),
    .crash_evt(evt2), .bus_rdata(rd2));

  crashrec_ctrl #(.LAYOUT_VER(0), .FILL_CYCLES(FILL), .ACCESS_KIND(4'd2),
    .RECORD_ID(32'hC0DE_5A17), .BASE_OFS(32'h0000_0100), .LOG_WORDS(32'd64)) u_crashrec_ctrl_v0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr0), .bus_wdata(wdata),
    .crash_evt(evt0), .bus_rdata(rd0));

  // expected layout 2 status word built from the flag list of the requirements
  function automatic logic [31:0] mk2(input logic c, b, cl, cs, e, ra, d);
    logic [31:0] w;
    w = 32'h0010_0000;
    w[31] = c; w[30] = b; w[29] = cl; w[28] = d; w[27] = cs; w[26] = e; w[25] = ra;
    return w;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel0, input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (sel0) wr0 = 1'b1; else wr2 = 1'b1;
    @(posedge clk); #1;
    wr0 = 1'b0; wr2 = 1'b0;
  endtask

  task automatic evt(input logic sel0);
    if (sel0) evt0 = 1'b1; else evt2 = 1'b1;
    @(posedge clk); #1;
    evt0 = 1'b0; evt2 = 1'b0;
  endtask

  // driver: queue the expected word, the monitor compares it
  task automatic rd(input logic sel0, input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    sbq.push_back('{sel0, exp, tag});
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin : monitor
    item_t it;
    logic [31:0] act;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      act = it.sel0 ? rd0 : rd2;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    rd(0, S, mk2(0,0,0,0,0,0,0), "R2 status after reset");
    rd(0, C, 32'h0, "R2 control after reset");
    rd(1, S, 32'h0, "R2 v0 word after reset");
    // discovery header
    rd(0, 8'h00, 32'h0002_0012, "R1 header v2");
    rd(0, 8'h04, 32'hC0DE_5A17, "R1 identifier");
    rd(0, 8'h08, 32'h0000_0100, "R1 base offset");
    rd(0, 8'h0C, 32'h0000_0040, "R1 size words");
    rd(1, 8'h00, 32'h0000_0012, "R1 header v0");
    // execute and fill timing
    wr(0, C, 32'h2000_0000);
    rd(0, S, mk2(0,1,0,0,0,0,0), "R3 in progress first cycle");
    tick(FILL - 2);
    rd(0, S, mk2(0,1,0,0,0,0,0), "R3 in progress last cycle");
    rd(0, S, mk2(1,0,0,0,0,0,0), "R3 complete after fill");
    // requests while complete
    wr(0, C, 32'h2000_0000);
    rd(0, S, mk2(1,0,0,0,0,0,0), "R4 execute ignored while complete");
    evt(0);
    rd(0, S, mk2(1,0,0,0,0,0,0), "R4 event ignored while complete");
    // consume, rearm, status write
    wr(0, C, 32'h0200_0000);
    rd(0, S, mk2(1,0,0,1,0,0,0), "R5 consume accepted");
    wr(0, C, 32'h1000_0000);
    rd(0, S, mk2(1,0,0,1,0,1,0), "R7 rearm sets rearmed");
    wr(0, S, 32'hFFFF_FFFF);
    rd(0, S, mk2(1,0,0,1,0,1,0), "R8 status write ignored");
    rd(0, C, 32'h0, "R8 action bits read zero");
    // clear and rejected consume
    wr(0, C, 32'h4000_0000);
    rd(0, S, mk2(0,0,1,0,0,1,0), "R6 clear");
    wr(0, C, 32'h0200_0000);
    rd(0, S, mk2(0,0,1,0,1,1,0), "R5 consume rejected sets error");
    // crash event capture drops cleared and rearmed
    evt(0);
    rd(0, S, mk2(0,1,0,0,1,0,0), "R7 capture drops cleared and rearmed");
    tick(FILL);
    rd(0, S, mk2(1,0,0,0,1,0,0), "R3 event capture completes");
    wr(0, C, 32'h4000_0000);
    rd(0, S, mk2(0,0,1,0,0,0,0), "R6 clear drops error");
    // retrigger while in progress
    wr(0, C, 32'h2000_0000);
    rd(0, S, mk2(0,1,0,0,0,0,0), "R3 second capture busy");
    wr(0, C, 32'h2000_0000);
    tick(FILL - 3);
    rd(0, S, mk2(0,1,0,0,0,0,0), "R4 retrigger busy last cycle");
    rd(0, S, mk2(1,0,0,0,0,0,0), "R4 retrigger did not restart timer");
    // same-write precedence
    wr(0, C, 32'h6000_0000);
    rd(0, S, mk2(0,0,1,0,0,0,0), "R10 clear beats execute");
    tick(FILL);
    rd(0, S, mk2(0,0,1,0,0,0,0), "R10 no late capture");
    wr(0, C, 32'h2000_0000);
    tick(FILL);
    wr(0, C, 32'h4200_0000);
    rd(0, S, mk2(0,0,1,0,0,0,0), "R10 clear beats consume");
    // disable
    wr(0, C, 32'h8000_0000);
    rd(0, C, 32'h8000_0000, "R8 disable reads back");
    rd(0, S, mk2(0,0,1,0,0,0,1), "R8 disabled mirrored");
    wr(0, C, 32'hA000_0000);
    rd(0, S, mk2(0,0,1,0,0,0,1), "R4 execute ignored while disabled");
    evt(0);
    tick(FILL);
    rd(0, S, mk2(0,0,1,0,0,0,1), "R4 event ignored while disabled");
    wr(0, C, 32'h0);
    wr(0, C, 32'h2000_0000);
    tick(FILL);
    rd(0, S, mk2(1,0,0,0,0,0,0), "R3 capture after enable");
    wr(0, C, 32'h8000_0000);
    wr(0, C, 32'h8200_0000);
    rd(0, S, mk2(1,0,0,0,1,0,1), "R5 consume rejected while disabled");
    // reset again
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    rd(0, S, mk2(0,0,0,0,0,0,0), "R2 status after second reset");
    rd(0, C, 32'h0, "R2 enabled after second reset");
    // layout 0
    wr(1, S, 32'h4000_0000);
    rd(1, S, 32'h0, "R9 v0 busy not visible");
    tick(FILL);
    rd(1, S, 32'h8000_0000, "R9 v0 complete");
    wr(1, S, 32'h8000_0000);
    rd(1, S, 32'h8000_0000, "R9 v0 write-back fires nothing");
    wr(1, S, 32'h2000_0000);
    rd(1, S, 32'h0, "R6 v0 clear drops complete");
    wr(1, C, 32'hFFFF_FFFF);
    rd(1, C, 32'h0, "R9 v0 offset 0x14 reads zero");
    tick(FILL);
    rd(1, S, 32'h0, "R9 v0 offset 0x14 not decoded");
    wr(1, S, 32'h1000_0000);
    rd(1, S, 32'h1000_0000, "R8 v0 disable reads back");
    wr(1, S, 32'h5000_0000);
    tick(FILL);
    rd(1, S, 32'h1000_0000, "R4 v0 execute ignored while disabled");
    wr(1, S, 32'h6000_0000);
    tick(FILL);
    rd(1, S, 32'h0, "R10 v0 clear beats execute");
    evt(1);
    tick(FILL);
    rd(1, S, 32'h8000_0000, "R3 v0 event capture");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule